// File: doc/BRIEF.md
# Two-Deep Command Queue with Stacked Interrupt Snapshots

This block sits between a host that writes command bytes and a command execution engine. Ordinary commands are held in a two-slot queue: the engine is handed the bottom slot with a one-cycle start pulse, and when the engine signals completion, the waiting top slot drops to the bottom and is started in turn. Three urgent commands (device reset, bus reset and DMA stop) never enter the queue. They are passed straight to a separate urgent-start output on the next cycle.

When a command completes and its operation is one that reports, the block captures a snapshot. The snapshot holds the engine's status flags, an interrupt reason, an internal state value and the bus phase. Up to two snapshots are held. The oldest one is presented on the interrupt-status outputs, and an active-low interrupt line is driven from a register. A read strobe of the interrupt-status register retires the presented snapshot and brings the stacked one forward. A sticky error flag records a command write that found both queue slots occupied.

Top module: `cmd_queue_irq`

## Requirements
- R1: A written command whose low seven bits are not an urgent code enters the queue. The command in the bottom slot is shown on `exe_cmd` together with a one-cycle `exe_start` pulse. The pulse comes one clock after the command reaches the bottom slot while no command is executing.
- R2: `exe_done` completes the executing command. The top slot then moves to the bottom and is started one clock later. `exe_done` has no effect while no command is executing.
- R3: Low seven bits 0x02 (device reset), 0x03 (bus reset) and 0x04 (DMA stop) mark urgent commands, whatever the value of bit 7. Such a write is not queued. It produces `urg_start` for one cycle, with the full byte on `urg_cmd`, on the clock after the write.
- R4: A queued write that finds both slots occupied, in a cycle with no completion, is discarded and sets `cmd_err`. An `isr_rd` strobe clears `cmd_err`. If a new overflow happens in the same cycle as the strobe, the flag is set.
- R5: `cmd_rdata` shows the bottom-slot command while one is held. Otherwise it shows the most recent completed or urgent command. It reads 0 after reset.
- R6: A completion raises no interrupt when its low seven bits are 0x00, 0x01, 0x1A, 0x1B, 0x27 or 0x44. Any other completion stores a snapshot of `exe_status`, `exe_reason`, `exe_state` and `bus_phase` as sampled in the completion cycle.
- R7: `irq_n` goes low on the clock after a snapshot is stored into an empty stack. It stays low until a read leaves the stack empty.
- R8: A second snapshot waits behind the first. An `isr_rd` then presents the second one and `irq_n` stays low. A snapshot that arrives while two are held is dropped.
- R9: An `isr_rd` strobe that retires the only snapshot raises `irq_n` on the next clock. `int_status`, `int_reason` and `int_state` read 0 while no snapshot is presented.
- R10: With `latch_en` high and a snapshot presented, `phase_out` shows the phase captured in that snapshot. Otherwise `phase_out` follows `bus_phase` live.
- R11: A device reset empties both slots and abandons the executing command. It also empties the snapshot stack and clears `cmd_err`. A bus reset or DMA stop leaves the queue, the stack and `irq_n` unchanged.
- R12: While reset is held, `irq_n` is 1, and `exe_start`, `urg_start`, `cmd_err` and `cmd_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_wr | input | 1 | Command byte write strobe |
| cmd_wdata | input | 8 | Command byte; bit 7 marks DMA, bits 6:0 the operation |
| cmd_rdata | output | 8 | Bottom-slot command, or the last completed or urgent command |
| cmd_err | output | 1 | Sticky queue-overflow flag |
| exe_start | output | 1 | One-cycle start pulse to the engine |
| exe_cmd | output | 8 | Command handed to the engine |
| exe_done | input | 1 | Engine completion of the executing command |
| exe_status | input | STAT_W | Status flags supplied at completion |
| exe_reason | input | RSN_W | Interrupt reason supplied at completion |
| exe_state | input | ST_W | Internal state value supplied at completion |
| urg_start | output | 1 | One-cycle start pulse for an urgent command |
| urg_cmd | output | 8 | Urgent command byte |
| isr_rd | input | 1 | Read strobe of the interrupt-status register |
| latch_en | input | 1 | Selects the captured phase while a snapshot is presented |
| bus_phase | input | PH_W | Live bus phase bits |
| int_status | output | STAT_W | Presented snapshot status flags |
| int_reason | output | RSN_W | Presented snapshot interrupt reason |
| int_state | output | ST_W | Presented snapshot internal state |
| phase_out | output | PH_W | Captured or live bus phase |
| irq_n | output | 1 | Interrupt request, active low, registered |

## Verification
A slot that shifts wrongly or loses its valid bit shows up at `exe_cmd` or `cmd_rdata` within one to two clocks of the next completion, because the following start pulse names the wrong byte or never comes. A stack that is out of order or miscounted shows up on the cycle after an `isr_rd` strobe. At that point `irq_n` rises too early or stays low, or the presented reason, state and phase fields do not match the completion that produced them. A stray bypass or flush is visible the next clock on `urg_start`, `cmd_err` and `irq_n`, so long random sequences that mix every opcode class with reads and completions compared on each clock expose such faults near their cause.

// File: rtl/cq_pkg.sv
package cq_pkg;
    localparam int CMD_W = 8;

    localparam logic [6:0] OP_NOP     = 7'h00;
    localparam logic [6:0] OP_FIFOCLR = 7'h01;
    localparam logic [6:0] OP_DEVRST  = 7'h02;
    localparam logic [6:0] OP_BUSRST  = 7'h03;
    localparam logic [6:0] OP_DMASTOP = 7'h04;
    localparam logic [6:0] OP_ATN_ON  = 7'h1A;
    localparam logic [6:0] OP_ATN_OFF = 7'h1B;
    localparam logic [6:0] OP_DISC    = 7'h27;
    localparam logic [6:0] OP_SELEN   = 7'h44;

    // urgent operations skip the queue
    function automatic logic op_urgent(input logic [6:0] op);
        return (op == OP_DEVRST) || (op == OP_BUSRST) || (op == OP_DMASTOP);
    endfunction

    // operations whose completion raises no interrupt
    function automatic logic op_quiet(input logic [6:0] op);
        return (op == OP_NOP) || (op == OP_FIFOCLR) || (op == OP_ATN_ON) ||
               (op == OP_ATN_OFF) || (op == OP_DISC) || (op == OP_SELEN) ||
               op_urgent(op);
    endfunction
endpackage

// File: rtl/cq_slots.sv
module cq_slots #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [CW-1:0] wdata,
    input  logic          byp,
    input  logic [CW-1:0] byp_cmd,
    input  logic          flush,
    input  logic          done,
    input  logic          clr_err,
    output logic          start,
    output logic [CW-1:0] cur,
    output logic [CW-1:0] rdata,
    output logic          err,
    output logic          fin,
    output logic [6:0]    fin_op
);
    typedef struct packed {
        logic [CW-1:0] bot;
        logic [CW-1:0] top;
        logic [CW-1:0] last;
        logic          bot_v;
        logic          top_v;
        logic          run;
        logic          start;
        logic          err;
    } slot_t;

    slot_t q, d;

    assign fin = done && q.run;

    always_comb begin
        d       = q;
        d.start = 1'b0;
        if (fin) begin
            d.last  = q.bot;
            d.run   = 1'b0;
            d.bot   = q.top;
            d.bot_v = q.top_v;
            d.top_v = 1'b0;
        end
        if (q.bot_v && !q.run) begin
            d.start = 1'b1;
            d.run   = 1'b1;
        end
        d.err = q.err & ~clr_err;
        if (wr) begin
            if (!d.bot_v) begin
                d.bot   = wdata;
                d.bot_v = 1'b1;
            end else if (!d.top_v) begin
                d.top   = wdata;
                d.top_v = 1'b1;
            end else begin
                d.err = 1'b1;
            end
        end
        if (byp) d.last = byp_cmd;
        if (flush) begin
            d.bot_v = 1'b0;
            d.top_v = 1'b0;
            d.run   = 1'b0;
            d.start = 1'b0;
            d.err   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign start  = q.start;
    assign cur    = q.bot;
    assign rdata  = q.bot_v ? q.bot : q.last;
    assign err    = q.err;
    assign fin_op = q.bot[6:0];
endmodule

// File: rtl/cq_snapstk.sv
module cq_snapstk #(
    parameter int SW = 19
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [SW-1:0] pdata,
    input  logic          pop,
    input  logic          flush,
    output logic          head_v,
    output logic [SW-1:0] head,
    output logic          irq_n
);
    typedef struct packed {
        logic [SW-1:0] s0;
        logic [SW-1:0] s1;
        logic          v0;
        logic          v1;
        logic          irq_n;
    } stk_t;

    stk_t q, d;

    always_comb begin
        d = q;
        if (pop && q.v0) begin
            d.s0 = q.s1;
            d.v0 = q.v1;
            d.v1 = 1'b0;
        end
        if (push) begin
            if (!d.v0) begin
                d.s0 = pdata;
                d.v0 = 1'b1;
            end else if (!d.v1) begin
                d.s1 = pdata;
                d.v1 = 1'b1;
            end
        end
        if (flush) begin
            d.v0 = 1'b0;
            d.v1 = 1'b0;
        end
        d.irq_n = ~d.v0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{s0: '0, s1: '0, v0: 1'b0, v1: 1'b0, irq_n: 1'b1};
        else        q <= d;
    end

    assign head_v = q.v0;
    assign head   = q.s0;
    assign irq_n  = q.irq_n;
endmodule

// File: rtl/cmd_queue_irq.sv
module cmd_queue_irq #(
    parameter int STAT_W = 5,
    parameter int RSN_W  = 8,
    parameter int ST_W   = 3,
    parameter int PH_W   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_wr,
    input  logic [cq_pkg::CMD_W-1:0] cmd_wdata,
    output logic [cq_pkg::CMD_W-1:0] cmd_rdata,
    output logic                     cmd_err,
    output logic                     exe_start,
    output logic [cq_pkg::CMD_W-1:0] exe_cmd,
    input  logic                     exe_done,
    input  logic [STAT_W-1:0]        exe_status,
    input  logic [RSN_W-1:0]         exe_reason,
    input  logic [ST_W-1:0]          exe_state,
    output logic                     urg_start,
    output logic [cq_pkg::CMD_W-1:0] urg_cmd,
    input  logic                     isr_rd,
    input  logic                     latch_en,
    input  logic [PH_W-1:0]          bus_phase,
    output logic [STAT_W-1:0]        int_status,
    output logic [RSN_W-1:0]         int_reason,
    output logic [ST_W-1:0]          int_state,
    output logic [PH_W-1:0]          phase_out,
    output logic                     irq_n
);
    import cq_pkg::*;

    localparam int SNAP_W = PH_W + ST_W + RSN_W + STAT_W;
    localparam int RSN_LO = STAT_W;
    localparam int ST_LO  = STAT_W + RSN_W;
    localparam int PH_LO  = STAT_W + RSN_W + ST_W;

    typedef struct packed {
        logic             go;
        logic [CMD_W-1:0] cmd;
    } urg_t;

    urg_t u_q, u_d;

    logic              byp, devrst, fin, push, head_v;
    logic [6:0]        fin_op;
    logic [SNAP_W-1:0] head;

    assign byp    = cmd_wr && op_urgent(cmd_wdata[6:0]);
    assign devrst = byp && (cmd_wdata[6:0] == OP_DEVRST);

    cq_slots #(.CW(CMD_W)) u_slots (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (cmd_wr && !byp),
        .wdata   (cmd_wdata),
        .byp     (byp),
        .byp_cmd (cmd_wdata),
        .flush   (devrst),
        .done    (exe_done),
        .clr_err (isr_rd),
        .start   (exe_start),
        .cur     (exe_cmd),
        .rdata   (cmd_rdata),
        .err     (cmd_err),
        .fin     (fin),
        .fin_op  (fin_op)
    );

    assign push = fin && !op_quiet(fin_op) && !devrst;

    cq_snapstk #(.SW(SNAP_W)) u_stack (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (push),
        .pdata  ({bus_phase, exe_state, exe_reason, exe_status}),
        .pop    (isr_rd),
        .flush  (devrst),
        .head_v (head_v),
        .head   (head),
        .irq_n  (irq_n)
    );

    always_comb begin
        u_d.go  = byp;
        u_d.cmd = byp ? cmd_wdata : u_q.cmd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) u_q <= '0;
        else        u_q <= u_d;
    end

    assign urg_start  = u_q.go;
    assign urg_cmd    = u_q.cmd;
    assign int_status = head_v ? head[STAT_W-1:0]        : '0;
    assign int_reason = head_v ? head[RSN_LO +: RSN_W]   : '0;
    assign int_state  = head_v ? head[ST_LO +: ST_W]     : '0;
    assign phase_out  = (latch_en && head_v) ? head[PH_LO +: PH_W] : bus_phase;
endmodule

// File: rtl/cmd_queue_irq_chk.sv
module cmd_queue_irq_chk #(
    parameter int STAT_W = 5,
    parameter int RSN_W  = 8,
    parameter int ST_W   = 3,
    parameter int PH_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_wr,
    input logic [7:0]        cmd_wdata,
    input logic              cmd_err,
    input logic              exe_start,
    input logic              urg_start,
    input logic [7:0]        urg_cmd,
    input logic              isr_rd,
    input logic [PH_W-1:0]   bus_phase,
    input logic [STAT_W-1:0] int_status,
    input logic [RSN_W-1:0]  int_reason,
    input logic [ST_W-1:0]   int_state,
    input logic [PH_W-1:0]   phase_out,
    input logic              irq_n
);
    import cq_pkg::*;

    // R1: a start pulse lasts one cycle
    a_r1_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        exe_start |=> !exe_start);

    // R3: urgent write starts on the next clock with the same byte
    a_r3_urgent_next: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && op_urgent(cmd_wdata[6:0])) |=> (urg_start && urg_cmd == $past(cmd_wdata)));

    // R4: the error flag only rises after a write
    a_r4_err_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_err) |-> $past(cmd_wr));

    // R7: a pending interrupt holds until a read or a device reset
    a_r7_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && !isr_rd && !(cmd_wr && cmd_wdata[6:0] == OP_DEVRST)) |=> !irq_n);

    // R9: no snapshot fields while no interrupt is pending
    a_r9_quiet_fields: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n |-> (int_status == '0 && int_reason == '0 && int_state == '0));

    // R10: with nothing presented the phase is live
    a_r10_live_phase: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n |-> (phase_out == bus_phase));

    // R11: a device reset clears interrupt, error and start
    a_r11_devrst_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_wdata[6:0] == OP_DEVRST) |=> (irq_n && !cmd_err && !exe_start));
endmodule

bind cmd_queue_irq cmd_queue_irq_chk #(
    .STAT_W(STAT_W), .RSN_W(RSN_W), .ST_W(ST_W), .PH_W(PH_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_wr     (cmd_wr),
    .cmd_wdata  (cmd_wdata),
    .cmd_err    (cmd_err),
    .exe_start  (exe_start),
    .urg_start  (urg_start),
    .urg_cmd    (urg_cmd),
    .isr_rd     (isr_rd),
    .bus_phase  (bus_phase),
    .int_status (int_status),
    .int_reason (int_reason),
    .int_state  (int_state),
    .phase_out  (phase_out),
    .irq_n      (irq_n)
);

// File: tb/test_cmd_queue_irq.sv
`timescale 1ns/1ps
module test_cmd_queue_irq;
    localparam int STW = 5;
    localparam int RSW = 8;
    localparam int SW  = 3;
    localparam int PW  = 3;
    localparam int SNW = PW + SW + RSW + STW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_wr = 1'b0;
    logic [7:0] cmd_wdata = '0;
    logic exe_done = 1'b0;
    logic [STW-1:0] exe_status = '0;
    logic [RSW-1:0] exe_reason = '0;
    logic [SW-1:0] exe_state = '0;
    logic isr_rd = 1'b0;
    logic latch_en = 1'b0;
    logic [PW-1:0] bus_phase = '0;
    logic [7:0] cmd_rdata, exe_cmd, urg_cmd;
    logic cmd_err, exe_start, urg_start, irq_n;
    logic [STW-1:0] int_status;
    logic [RSW-1:0] int_reason;
    logic [SW-1:0] int_state;
    logic [PW-1:0] phase_out;

    always #4 clk = ~clk;

    cmd_queue_irq i_cmd_queue_irq (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .cmd_rdata(cmd_rdata), .cmd_err(cmd_err), .exe_start(exe_start),
        .exe_cmd(exe_cmd), .exe_done(exe_done), .exe_status(exe_status),
        .exe_reason(exe_reason), .exe_state(exe_state), .urg_start(urg_start),
        .urg_cmd(urg_cmd), .isr_rd(isr_rd), .latch_en(latch_en),
        .bus_phase(bus_phase), .int_status(int_status), .int_reason(int_reason),
        .int_state(int_state), .phase_out(phase_out), .irq_n(irq_n)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit live = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // reference model
    logic [7:0]     mq[$];
    logic [SNW-1:0] ms[$];
    bit m_run, m_start, m_err, m_urg;
    logic [7:0] m_urgc, m_last;

    function automatic bit is_urg(input logic [6:0] op);
        return op == 7'h02 || op == 7'h03 || op == 7'h04;
    endfunction
    function automatic bit no_irq(input logic [6:0] op);
        return op == 7'h00 || op == 7'h01 || op == 7'h1A || op == 7'h1B ||
               op == 7'h27 || op == 7'h44;
    endfunction

    bit o_run, fin_now;
    int o_sz;
    logic [7:0] fc;
    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete(); ms.delete();
            m_run = 0; m_start = 0; m_err = 0; m_urg = 0; m_urgc = 0; m_last = 0;
        end else begin
            o_run = m_run;
            o_sz = mq.size();
            fin_now = exe_done && o_run;
            m_start = 0;
            m_urg = 0;
            if (isr_rd && ms.size() > 0) void'(ms.pop_front());
            if (fin_now) begin
                fc = mq.pop_front();
                m_last = fc;
                m_run = 0;
                if (!no_irq(fc[6:0]) && ms.size() < 2)
                    ms.push_back({bus_phase, exe_state, exe_reason, exe_status});
            end
            if (o_sz > 0 && !o_run) begin
                m_start = 1; m_run = 1;
            end
            if (isr_rd) m_err = 0;
            if (cmd_wr) begin
                if (is_urg(cmd_wdata[6:0])) begin
                    m_urg = 1; m_urgc = cmd_wdata; m_last = cmd_wdata;
                    if (cmd_wdata[6:0] == 7'h02) begin
                        mq.delete(); ms.delete();
                        m_run = 0; m_start = 0; m_err = 0;
                    end
                end else if (mq.size() < 2) begin
                    mq.push_back(cmd_wdata);
                end else begin
                    m_err = 1;
                end
            end
        end
    end

    logic [SNW-1:0] hd;
    always @(negedge clk) begin
        if (live) begin
            hd = (ms.size() > 0) ? ms[0] : '0;
            chk("R1 exe_start", exe_start, m_start);
            if (m_start) chk("R1 exe_cmd", exe_cmd, mq[0]);
            chk("R5 cmd_rdata", cmd_rdata, (mq.size() > 0) ? mq[0] : m_last);
            chk("R4 cmd_err", cmd_err, m_err);
            chk("R3 urg_start", urg_start, m_urg);
            if (m_urg) chk("R3 urg_cmd", urg_cmd, m_urgc);
            chk("R7 irq_n", irq_n, ms.size() == 0);
            chk("R6 int_status", int_status, hd[STW-1:0]);
            chk("R8 int_reason", int_reason, hd[STW +: RSW]);
            chk("R9 int_state", int_state, hd[STW+RSW +: SW]);
            chk("R10 phase_out", phase_out,
                (latch_en && ms.size() > 0) ? hd[SNW-1 -: PW] : bus_phase);
        end
    end

    // engine data changes every cycle
    always @(negedge clk) begin
        #2;
        exe_status = STW'($urandom);
        exe_reason = RSW'($urandom);
        exe_state  = SW'($urandom);
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask
    task automatic put(input logic [7:0] b);
        cmd_wdata = b; cmd_wr = 1'b1; tick(); cmd_wr = 1'b0;
    endtask
    task automatic fin1();
        exe_done = 1'b1; tick(); exe_done = 1'b0;
    endtask
    task automatic rd1();
        isr_rd = 1'b1; tick(); isr_rd = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    logic [7:0] pick [11] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h84, 8'h1A,
                               8'h10, 8'h91, 8'h27, 8'h44, 8'h55};
    initial begin
        repeat (3) tick();
        chk("R12 irq_n", irq_n, 1);
        chk("R12 exe_start", exe_start, 0);
        chk("R12 urg_start", urg_start, 0);
        chk("R12 cmd_err", cmd_err, 0);
        chk("R12 cmd_rdata", cmd_rdata, 0);
        rst_n = 1'b1;
        live = 1'b1;

        put(8'h10); tick(); tick(); fin1();
        chk("R7 irq after completion", irq_n, 0);
        rd1();
        chk("R9 irq cleared by read", irq_n, 1);
        chk("R9 state cleared", int_state, 0);

        put(8'h11); put(8'h12); put(8'h13);
        chk("R4 overflow flag", cmd_err, 1);
        rd1();
        chk("R4 flag cleared by read", cmd_err, 0);
        fin1();
        chk("R2 top moved to bottom", cmd_rdata, 8'h12);
        tick(); fin1();
        chk("R8 two held", irq_n, 0);
        rd1();
        chk("R8 second presented", irq_n, 0);
        rd1();
        chk("R8 stack drained", irq_n, 1);

        put(8'h00); tick(); tick(); fin1();
        chk("R6 quiet completion", irq_n, 1);

        latch_en = 1'b1;
        put(8'h20); tick(); tick();
        bus_phase = 3'b101; fin1(); bus_phase = 3'b010; tick();
        chk("R10 latched phase", phase_out, 3'b101);
        rd1(); tick();
        chk("R10 live phase", phase_out, 3'b010);

        put(8'h30); tick(); tick(); fin1();
        put(8'h03);
        chk("R11 bus reset keeps irq", irq_n, 0);
        chk("R3 bus reset byte", urg_cmd, 8'h03);
        put(8'h31); put(8'h32);
        put(8'h82);
        chk("R11 device reset clears irq", irq_n, 1);
        chk("R11 device reset empties queue", cmd_rdata, 8'h82);
        fin1();
        chk("R11 abandoned done ignored", irq_n, 1);
        latch_en = 1'b0;

        for (int i = 0; i < 3000; i++) begin
            cmd_wr    = ($urandom % 5) == 0;
            cmd_wdata = pick[$urandom % 11];
            exe_done  = ($urandom % 4) == 0;
            isr_rd    = ($urandom % 7) == 0;
            latch_en  = $urandom % 2;
            bus_phase = PW'($urandom);
            tick();
        end
        cmd_wr = 0; exe_done = 0; isr_rd = 0;
        tick();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule